// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block takes stereo PCM from a three-wire serial audio link (bit clock, word-select clock, data) and turns each frame into one signed 24-bit left and right sample pair, signalled by a one-cycle valid strobe. All three link wires are brought into the fast system clock domain through synchronizers. A rising edge of the bit clock is found by edge detection, and on that edge the data bit and the word-select level are both sampled. The bit clock must therefore run at no more than a quarter of the system clock.

A 3-bit format input chooses one of five framings, and all five share one shift engine. In the right-justified formats the word is taken from the last bits before the word-select transition, so the capture point depends on how many bit clocks the half-frame has. In the left-justified format the word is taken from the first bits after the transition. The I2S format is handled as left-justified with the word-select delayed by one bit. Shorter words are placed at the top of the 24-bit output.

Top module: `aud_serial_rx`

## Requirements
- R1: Format codes 0, 1 and 4 are right-justified with 16, 20 and 24-bit words. The word is the last 16/20/24 bits received before the word-select changes. Word-select high marks the left half. Earlier bits in the half are ignored.
- R2: Format code 2 is left-justified with word-select high for left. The word is the first min(24, bits in half) bits after the word-select change. Later bits in the half are ignored.
- R3: Format code 3 is I2S with word-select low for left. The MSB arrives on the second bit-clock rise after the word-select change. A 16-bit word is taken when a half holds 16 bit clocks, and a 24-bit word when a half holds 24 or more.
- R4: Every word is MSB first and two's complement. It is output with its MSB at bit 23, and the bits below a shorter word are zero.
- R5: The data and word-select levels are taken only at rising edges of the bit clock. The data may change while the bit clock is low.
- R6: valid_o is a single-cycle pulse, once per frame, after the right word of that frame has completed. left_o and right_o change only together with that pulse and hold their values otherwise.
- R7: A change of fmt_i discards the frame in progress. Output resumes with the first frame whose left half begins after the change.
- R8: After reset, valid_o is low and both samples read zero. The frame in progress at reset release produces no pulse.
- R9: Format codes 5, 6 and 7 are reserved, and while one of them is selected valid_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| frame_i | input | 1 | Word-select / frame clock (asynchronous) |
| data_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 3 | Framing select (0,1,4 right-justified; 2 left-justified; 3 I2S) |
| left_o | output | 24 | Left sample, left-aligned two's complement |
| right_o | output | 24 | Right sample, left-aligned two's complement |
| valid_o | output | 1 | One-cycle strobe when a new pair is presented |

## Verification
On a single bit-clock rise, the boundary that closes a frame's right word must publish the pair and also load the first bit of the next left word into the cleared shift register. In I2S that same rise also carries the previous right LSB. Frames are sent back to back with no idle bits in every format at several half-frame lengths, including the shortest allowed, so this overlap happens in every vector. It is judged by the exact values of the pair and by exactly one pulse per frame. A second overlap, a format change in the middle of a frame, is provoked between the two halves and judged by the absence of a pulse and by the held outputs.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
   localparam int WORD_W = 24;
   localparam int NB_W   = 5;

   // Right-justified framings (word taken at the end of the half)
   function automatic logic is_rjust(input logic [2:0] f);
      return (f == 3'd0) || (f == 3'd1) || (f == 3'd4);
   endfunction

   function automatic logic is_rsvd(input logic [2:0] f);
      return f > 3'd4;
   endfunction

   function automatic logic [NB_W-1:0] rjust_len(input logic [2:0] f);
      case (f)
         3'd0:    return NB_W'(16);
         3'd1:    return NB_W'(20);
         default: return NB_W'(24);
      endcase
   endfunction

   // Keep the low nb bits of sh and move them to the top of the word
   function automatic logic [WORD_W-1:0] left_align(input logic [WORD_W-1:0] sh,
                                                     input logic [NB_W-1:0]   nb);
      logic [31:0] mask;
      logic [31:0] kept;
      mask = (32'd1 << nb) - 32'd1;
      kept = {{(32-WORD_W){1'b0}}, sh} & mask;
      return WORD_W'(kept << (NB_W'(WORD_W) - nb));
   endfunction
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("aud_rx_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_st
      logic [W-1:0] q;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= g_st[g-1].q;
         end
      end
   end

   assign dout = g_st[STAGES-1].q;
endmodule

// File: rtl/aud_rx_framer.sv
module aud_rx_framer (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_s,
   input  logic ws_s,
   input  logic sd_s,
   input  logic i2s,
   output logic bit_stb,
   output logic bit_val,
   output logic bound,
   output logic ended_left
);
   logic       sck_q;
   logic       ws_h1, ws_h2;
   logic [1:0] seen;
   logic       eff_new, eff_old, hist_ok;

   assign bit_stb = sck_s & ~sck_q;
   assign bit_val = sd_s;

   // I2S is treated as left-justified with word-select delayed by one bit
   assign eff_new    = i2s ? ws_h1 : ws_s;
   assign eff_old    = i2s ? ws_h2 : ws_h1;
   assign hist_ok    = i2s ? (seen >= 2'd2) : (seen >= 2'd1);
   assign bound      = bit_stb & hist_ok & (eff_new != eff_old);
   assign ended_left = eff_old ^ i2s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         ws_h1 <= 1'b0;
         ws_h2 <= 1'b0;
         seen  <= 2'd0;
      end else begin
         sck_q <= sck_s;
         if (bit_stb) begin
            ws_h1 <= ws_s;
            ws_h2 <= ws_h1;
            if (seen != 2'd3) seen <= seen + 2'd1;
         end
      end
   end
endmodule

// File: rtl/aud_rx_shifter.sv
module aud_rx_shifter
   import aud_rx_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic              bound,
   input  logic [2:0]        fmt,
   output logic [WORD_W-1:0] word
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_WRD = CNT_W'(WORD_W);

   logic [WORD_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic [NB_W-1:0]   nbits;
   logic              rj;

   assign rj    = is_rjust(fmt);
   assign nbits = rj ? rjust_len(fmt)
                     : ((cnt >= CNT_WRD) ? NB_W'(WORD_W) : NB_W'(cnt));
   assign word  = left_align(sh, nbits);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
      end else if (bit_stb) begin
         if (bound) begin
            sh  <= {{(WORD_W-1){1'b0}}, bit_val};
            cnt <= CNT_W'(1);
         end else begin
            if (rj || (cnt < CNT_WRD)) sh <= {sh[WORD_W-2:0], bit_val};
            if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
         end
      end
   end

   // A half that closes has always carried at least one bit
   assert_nbits_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bound |-> (nbits != '0) && (nbits <= NB_W'(WORD_W)))
      else $error("half-frame closed with empty or oversize word");
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
   import aud_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_i,
   input  logic              frame_i,
   input  logic              data_i,
   input  logic [2:0]        fmt_i,
   output logic [WORD_W-1:0] left_o,
   output logic [WORD_W-1:0] right_o,
   output logic              valid_o
);
   if (CNT_W < NB_W + 1) begin : g_bad_cnt
      $error("aud_serial_rx: CNT_W too small to count a full word");
   end

   logic [2:0]        pins_s;
   logic [2:0]        fmt_q;
   logic              bit_stb, bit_val, bound, ended_left;
   logic [WORD_W-1:0] word, left_hold;
   logic              armed, have_left;

   aud_rx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({bclk_i, frame_i, data_i}),
      .dout (pins_s)
   );

   aud_rx_framer u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s     (pins_s[2]),
      .ws_s      (pins_s[1]),
      .sd_s      (pins_s[0]),
      .i2s       (fmt_q == 3'd3),
      .bit_stb   (bit_stb),
      .bit_val   (bit_val),
      .bound     (bound),
      .ended_left(ended_left)
   );

   aud_rx_shifter #(.CNT_W(CNT_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_stb(bit_stb),
      .bit_val(bit_val),
      .bound  (bound),
      .fmt    (fmt_q),
      .word   (word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q     <= 3'd3;
         armed     <= 1'b0;
         have_left <= 1'b0;
         left_hold <= '0;
         left_o    <= '0;
         right_o   <= '0;
         valid_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (fmt_i != fmt_q) begin
            fmt_q     <= fmt_i;
            armed     <= 1'b0;
            have_left <= 1'b0;
         end else if (bound) begin
            if (armed && ended_left) begin
               left_hold <= word;
               have_left <= 1'b1;
            end else if (armed && have_left) begin
               left_o    <= left_hold;
               right_o   <= word;
               valid_o   <= 1'b1;
               have_left <= 1'b0;
            end
            // a closing right half means a new frame starts here
            if (!ended_left) armed <= !is_rsvd(fmt_q);
         end
      end
   end

   assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o)
      else $error("valid strobe longer than one cycle");

   assert_valid_after_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(bound))
      else $error("valid strobe without a closing half-frame");

   assert_mode_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_i != fmt_q) |=> !valid_o)
      else $error("pair emitted across a format change");

   assert_reserved_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      is_rsvd(fmt_q) |=> !valid_o)
      else $error("pair emitted in a reserved format");
endmodule

// File: tb/sim_aud_serial_rx.sv
module sim_aud_serial_rx;
   localparam int HB = 4;   // system cycles per bit-clock phase
   localparam int NV = 11;
   // {mode[3:0], half length[7:0], left[23:0], right[23:0], pad[3:0]}
   localparam logic [63:0] VEC [NV] = '{
      {4'd0, 8'd16, 24'h00A5C3, 24'h00FF81, 4'h0},
      {4'd0, 8'd32, 24'h001234, 24'h008000, 4'h0},
      {4'd1, 8'd20, 24'h0ABCDE, 24'h080001, 4'h0},
      {4'd1, 8'd32, 24'h07FFFF, 24'h012345, 4'h0},
      {4'd4, 8'd24, 24'h800001, 24'h7FFFFE, 4'h0},
      {4'd4, 8'd32, 24'hC0FFEE, 24'h135790, 4'h0},
      {4'd2, 8'd24, 24'hABCDEF, 24'h012345, 4'h0},
      {4'd2, 8'd32, 24'h7F00FF, 24'hFF0080, 4'h0},
      {4'd3, 8'd16, 24'h00BEEF, 24'h007001, 4'h0},
      {4'd3, 8'd24, 24'h89ABCD, 24'h765432, 4'h0},
      {4'd3, 8'd32, 24'hF0F0F0, 24'h0F0F0F, 4'h0}
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bclk = 1'b0, frm = 1'b0, sd = 1'b0;
   logic [2:0]  fmt = 3'd0;
   logic [23:0] left_o, right_o;
   logic        valid_o;

   int          n_run = 0, n_fail = 0, vcnt = 0;
   logic [23:0] cap_l = '0, cap_r = '0;
   bit          i2s_carry = 1'b0;

   always #5 clk = ~clk;

   aud_serial_rx u0 (
      .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .frame_i(frm), .data_i(sd),
      .fmt_i(fmt), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
   );

   always @(negedge clk) if (rst_n && valid_o) begin
      vcnt++;
      cap_l = left_o;
      cap_r = right_o;
   end

   function automatic bit rj(input int m);
      return (m == 0) || (m == 1) || (m == 4);
   endfunction

   function automatic int wlen(input int m, input int hl);
      if (m == 0) return 16;
      if (m == 1) return 20;
      if (m == 4) return 24;
      return (hl >= 24) ? 24 : hl;
   endfunction

   function automatic logic [23:0] exp_word(input int m, input int hl, input logic [23:0] w);
      int n = wlen(m, hl);
      logic [31:0] v = {8'd0, w} & ((32'd1 << n) - 32'd1);
      return 24'(v << (24 - n));
   endfunction

   function automatic string req_of(input int m);
      if (m == 2) return "R2";
      if (m == 3) return "R3";
      return "R1";
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [23:0] act, input logic [23:0] expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   // data and word-select move only while the bit clock is low (R5)
   task automatic send_bit(input bit w, input bit d);
      @(negedge clk);
      frm = w;
      sd  = d;
      repeat (HB) @(negedge clk);
      bclk = 1'b1;
      repeat (HB) @(negedge clk);
      bclk = 1'b0;
   endtask

   task automatic send_half(input int m, input int hl, input logic [23:0] w, input bit is_left);
      int n = wlen(m, hl);
      bit wsv = (m == 3) ? !is_left : is_left;
      for (int k = 0; k < hl; k++) begin
         bit b;
         if (rj(m)) b = (k >= hl - n) ? w[n-1-(k-(hl-n))] : (k % 3 == 0);
         else       b = (k < n) ? w[n-1-k] : (k % 3 == 0);
         if (m == 3) begin
            send_bit(wsv, i2s_carry);
            i2s_carry = b;
         end else begin
            send_bit(wsv, b);
         end
      end
   endtask

   task automatic send_frame(input int m, input int hl, input logic [23:0] l, input logic [23:0] r);
      send_half(m, hl, l, 1'b1);
      send_half(m, hl, r, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected 0", 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [23:0] prev_l;
      repeat (5) @(negedge clk);
      // R8: reset state
      check(valid_o == 1'b0, "R8", "valid at reset", 24'(valid_o), 24'd0);
      check(left_o == '0, "R8", "left at reset", left_o, 24'd0);
      check(right_o == '0, "R8", "right at reset", right_o, 24'd0);
      rst_n = 1'b1;

      // R8: the frame under way at release is dropped
      vcnt = 0;
      send_frame(0, 16, 24'h001111, 24'h002222);
      send_frame(0, 16, 24'h00C3C3, 24'h003C3C);
      check(vcnt == 0, "R8", "pulses over first frames", 24'(vcnt), 24'd0);
      vcnt = 0;
      send_frame(0, 16, 24'h004444, 24'h005555);
      check(vcnt == 1, "R8", "pulse after first whole frame", 24'(vcnt), 24'd1);
      check(cap_l == 24'hC3C300, "R8", "left of first whole frame", cap_l, 24'hC3C300);
      check(cap_r == 24'h3C3C00, "R8", "right of first whole frame", cap_r, 24'h3C3C00);

      // table walk: R1/R2/R3 layout, R4 alignment, R5 rising-edge capture, R6 one pulse
      for (int i = 0; i < NV; i++) begin
         int m  = int'(VEC[i][63:60]);
         int hl = int'(VEC[i][59:52]);
         logic [23:0] lv = VEC[i][51:28];
         logic [23:0] rv = VEC[i][27:4];
         fmt = 3'(m);
         send_frame(m, hl, 24'h5A5A5A, 24'hA5A5A5);
         send_frame(m, hl, 24'h5A5A5A, 24'hA5A5A5);
         send_frame(m, hl, lv, rv);
         vcnt = 0;
         send_frame(m, hl, lv, rv);
         check(vcnt == 1, "R6", $sformatf("pulses per frame, vector %0d", i), 24'(vcnt), 24'd1);
         check(cap_l == exp_word(m, hl, lv), req_of(m), $sformatf("left R4, vector %0d", i),
               cap_l, exp_word(m, hl, lv));
         check(cap_r == exp_word(m, hl, rv), req_of(m), $sformatf("right R4, vector %0d", i),
               cap_r, exp_word(m, hl, rv));
      end

      // R7: format change between the halves of a frame
      fmt = 3'd2;
      send_frame(2, 32, 24'h111111, 24'h222222);
      send_frame(2, 32, 24'h333333, 24'h444444);
      send_half(2, 32, 24'h555555, 1'b1);
      vcnt   = 0;
      prev_l = left_o;
      fmt    = 3'd4;
      send_half(4, 32, 24'h666666, 1'b0);
      send_frame(4, 32, 24'h123456, 24'hFEDCBA);
      check(vcnt == 0, "R7", "pulses after mid-frame change", 24'(vcnt), 24'd0);
      check(left_o == prev_l, "R6", "left held without pulse", left_o, prev_l);
      send_frame(4, 32, 24'h0A0B0C, 24'h0D0E0F);
      check(vcnt == 1, "R7", "pulses once capture resumes", 24'(vcnt), 24'd1);
      check(cap_l == 24'h123456, "R7", "left after resume", cap_l, 24'h123456);
      check(cap_r == 24'hFEDCBA, "R7", "right after resume", cap_r, 24'hFEDCBA);

      // R9: reserved code keeps the strobe low
      fmt  = 3'd6;
      vcnt = 0;
      for (int f = 0; f < 3; f++) send_frame(2, 32, 24'h777777, 24'h888888);
      check(vcnt == 0, "R9", "pulses in reserved code", 24'(vcnt), 24'd0);
      check(left_o == 24'h123456, "R9", "left held in reserved code", left_o, 24'h123456);

      repeat (10) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule